// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block connects a single-word request port to a four-bank, 16-bit, single-data-rate SDRAM. It brings the memory up after reset, programs the mode register, and keeps the array refreshed on a schedule derived from 4096 refreshes per 64 ms at the configured clock rate. It turns each accepted request into an activate followed by a read or a write with auto precharge. There are no open rows to track, and each access returns the bank to idle.

A request carries a flat word address that is split into bank, row and column. It also carries a direction, a write word and a per-byte block mask. Read data comes back on a response strobe a fixed number of cycles after the read command: the programmed CAS latency, 2 or 3, plus one capture register. Only one access is in flight at a time. A refresh that falls due waits for the current access to finish and then takes the slot ahead of any new request.

All command, address, mask and write-data pins are driven from registers. The data bus is split into an output word, an output enable and an input word, so the pad ring can form the bidirectional pins.

Top module: `sdr_seq_ctrl`

## Requirements
- R1: From reset until INIT_CYC cycles have passed, sd_cke is low and sd_cs_n is high. sd_cke is high for at least one sampled cycle before any command with sd_cs_n low.
- R2: The start-up sequence is: precharge-all with sd_addr[10]=1, then two refreshes, then a mode register set with sd_ba=0, sd_addr[2:0]=000 (one-word burst), sd_addr[3]=0 (sequential) and sd_addr[6:4]=CAS_LAT. req_ready stays low until that sequence has completed.
- R3: req_addr is split as {bank[21:20], row[19:8], column[7:0]}. Activate drives bank on sd_ba and row on sd_addr. Read and write drive bank on sd_ba, column on sd_addr[7:0] and sd_addr[10]=1 (auto precharge).
- R4: Commands are encoded on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, no-op 0111, deselect 1xxx. No other pattern is issued.
- R5: Activate to read/write is at least T_RCD cycles. A bank is not reactivated and no refresh is issued until its precharge has had T_RP cycles, counted from the write plus T_WR or from the read plus one. Nothing but no-ops follows a refresh for T_RFC cycles.
- R6: For each read, rsp_valid pulses exactly CAS_LAT+1 cycles after the read command is on the pins, with rsp_rdata equal to the stored word. Responses come back in request order.
- R7: A write puts req_wdata on sd_dq_out with sd_dq_oe high only in the write-command cycle, and drives sd_dqm=req_mask there (bit 0 low byte, bit 1 high byte, 1 = lane blocked). Blocked lanes keep their previous content.
- R8: Refreshes are at most REFI + T_RCD + T_WR + T_RP + CAS_LAT + 4 cycles apart once running, where REFI = CLK_MHZ*64000/4096.
- R9: While a refresh is pending, req_ready is low, so a continuous stream of requests cannot postpone refresh beyond one access.
- R10: req_ready is high only when the block is idle. It drops in the cycle after a request is accepted and stays low until that access has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all pins change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Byte lanes to block on write, bit 0 low byte |
| rsp_valid | output | 1 | Read word present for one cycle |
| rsp_rdata | output | 16 | Read word |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte lane mask |
| sd_dq_out | output | 16 | Write data to the pads |
| sd_dq_oe | output | 1 | Pad output enable |
| sd_dq_in | input | 16 | Read data from the pads |

## Verification
The bench builds the block with CAS_LAT=3, CLK_MHZ=4 (a 62-cycle refresh interval), INIT_CYC=40, T_RCD=3, T_RP=3, T_RFC=7 and T_WR=2. The short interval makes refresh collide with streamed requests dozens of times in a few thousand cycles, so the priority rule and the refresh-gap bound are exercised repeatedly rather than once. The short start-up wait brings the full power-up sequence within reach. The behavioural memory in the bench drives read data only in the single slot that CAS latency 3 allows. The default CAS latency of 2 is reached only through elaboration with default parameters.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111,
        CMD_DESL = 4'b1111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR, ST_CKE, ST_PRE, ST_IREF, ST_MRS, ST_IDLE, ST_ACC, ST_WAIT
    } sdr_st_e;

    // low mode bits: burst of one word, sequential, latency in [6:4]
    function automatic logic [6:0] mode_low(input int cl);
        logic [6:0] m;
        m      = '0;
        m[6:4] = 3'(cl);
        return m;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REFI = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(REFI + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (cnt_q == CW'(REFI - 1)) begin
                cnt_q  <= '0;
                pend_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (ack) pend_q <= 1'b0;
            end
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DQ_W    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_on_bus,
    input  logic [DQ_W-1:0] dq_in,
    output logic            valid,
    output logic [DQ_W-1:0] data
);
    logic [CAS_LAT-1:0] pipe_q;
    logic               valid_q;
    logic [DQ_W-1:0]    data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q  <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            pipe_q  <= {pipe_q[CAS_LAT-2:0], rd_on_bus};
            valid_q <= pipe_q[CAS_LAT-1];
            if (pipe_q[CAS_LAT-1]) data_q <= dq_in;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
endmodule

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
    import sdr_seq_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 12,
    parameter int COL_W    = 8,
    parameter int DQ_W     = 16,
    parameter int CAS_LAT  = 2,
    parameter int CLK_MHZ  = 100,
    parameter int INIT_CYC = 20000,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int T_RFC    = 7,
    parameter int T_WR     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0]     req_addr,
    input  logic [DQ_W-1:0]                   req_wdata,
    input  logic [DQ_W/8-1:0]                 req_mask,
    output logic                              rsp_valid,
    output logic [DQ_W-1:0]                   rsp_rdata,
    output logic                              sd_cke,
    output logic                              sd_cs_n,
    output logic                              sd_ras_n,
    output logic                              sd_cas_n,
    output logic                              sd_we_n,
    output logic [BANK_W-1:0]                 sd_ba,
    output logic [ROW_W-1:0]                  sd_addr,
    output logic [DQ_W/8-1:0]                 sd_dqm,
    output logic [DQ_W-1:0]                   sd_dq_out,
    output logic                              sd_dq_oe,
    input  logic [DQ_W-1:0]                   sd_dq_in
);
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int MASK_W = DQ_W / 8;
    localparam int REFI   = (CLK_MHZ * 64000) / 4096;
    localparam int T_MRD  = 2;
    localparam int CNT_W  = $clog2(INIT_CYC + T_RFC + T_WR + T_RP + CAS_LAT + T_RCD + 2);

    typedef struct packed {
        sdr_st_e           st;
        sdr_st_e           ret;
        logic [CNT_W-1:0]  cnt;
        logic              second;
        logic              cke;
        sdr_cmd_e          cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  addr;
        logic [MASK_W-1:0] dqm;
        logic [DQ_W-1:0]   dq;
        logic              dq_oe;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [DQ_W-1:0]   wdata;
        logic [MASK_W-1:0] mask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ref_pend;
    logic ref_ack;

    sdr_refresh_timer #(.REFI(REFI)) u_refresh (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_on_bus(ctl_q.cmd == CMD_RD),
        .dq_in    (sd_dq_in),
        .valid    (rsp_valid),
        .data     (rsp_rdata)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cmd   = CMD_NOP;
        ctl_d.dq_oe = 1'b0;
        ctl_d.dqm   = '0;
        ref_ack     = 1'b0;
        unique case (ctl_q.st)
            ST_PWR: begin
                ctl_d.cmd = CMD_DESL;
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_CKE;
                    ctl_d.cke = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_CKE: ctl_d.st = ST_PRE;
            ST_PRE: begin
                ctl_d.cmd      = CMD_PRE;
                ctl_d.addr     = '0;
                ctl_d.addr[10] = 1'b1;
                ctl_d.cnt      = CNT_W'(T_RP - 2);
                ctl_d.ret      = ST_IREF;
                ctl_d.second   = 1'b0;
                ctl_d.st       = ST_WAIT;
            end
            ST_IREF: begin
                ctl_d.cmd    = CMD_REF;
                ctl_d.cnt    = CNT_W'(T_RFC - 2);
                ctl_d.ret    = ctl_q.second ? ST_MRS : ST_IREF;
                ctl_d.second = 1'b1;
                ctl_d.st     = ST_WAIT;
            end
            ST_MRS: begin
                ctl_d.cmd       = CMD_MRS;
                ctl_d.ba        = '0;
                ctl_d.addr      = '0;
                ctl_d.addr[6:0] = mode_low(CAS_LAT);
                ctl_d.cnt       = CNT_W'(T_MRD - 2);
                ctl_d.ret       = ST_IDLE;
                ctl_d.st        = ST_WAIT;
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    ctl_d.cmd = CMD_REF;
                    ref_ack   = 1'b1;
                    ctl_d.cnt = CNT_W'(T_RFC - 2);
                    ctl_d.ret = ST_IDLE;
                    ctl_d.st  = ST_WAIT;
                end else if (req_valid) begin
                    ctl_d.cmd   = CMD_ACT;
                    ctl_d.ba    = req_addr[ADDR_W-1 -: BANK_W];
                    ctl_d.addr  = req_addr[COL_W +: ROW_W];
                    ctl_d.bank  = req_addr[ADDR_W-1 -: BANK_W];
                    ctl_d.col   = req_addr[COL_W-1:0];
                    ctl_d.we    = req_we;
                    ctl_d.wdata = req_wdata;
                    ctl_d.mask  = req_mask;
                    ctl_d.cnt   = CNT_W'(T_RCD - 2);
                    ctl_d.ret   = ST_ACC;
                    ctl_d.st    = ST_WAIT;
                end
            end
            ST_ACC: begin
                ctl_d.cmd             = ctl_q.we ? CMD_WR : CMD_RD;
                ctl_d.ba              = ctl_q.bank;
                ctl_d.addr            = '0;
                ctl_d.addr[COL_W-1:0] = ctl_q.col;
                ctl_d.addr[10]        = 1'b1;
                if (ctl_q.we) begin
                    ctl_d.dq_oe = 1'b1;
                    ctl_d.dq    = ctl_q.wdata;
                    ctl_d.dqm   = ctl_q.mask;
                    ctl_d.cnt   = CNT_W'(T_WR + T_RP - 2);
                end else begin
                    ctl_d.cnt   = CNT_W'(CAS_LAT + T_RP - 2);
                end
                ctl_d.ret = ST_IDLE;
                ctl_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ctl_q.ret;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= ST_PWR;
            ctl_q.ret <= ST_IDLE;
            ctl_q.cnt <= CNT_W'(INIT_CYC - 1);
            ctl_q.cmd <= CMD_DESL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE) && !ref_pend;
    assign sd_cke    = ctl_q.cke;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = ctl_q.cmd;
    assign sd_ba     = ctl_q.ba;
    assign sd_addr   = ctl_q.addr;
    assign sd_dqm    = ctl_q.dqm;
    assign sd_dq_out = ctl_q.dq;
    assign sd_dq_oe  = ctl_q.dq_oe;

endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
    parameter int CAS_LAT = 2,
    parameter int T_RCD   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic dq_oe,
    input logic rsp_valid,
    input logic ref_pend,
    input logic req_ready
);
    logic is_act, is_rd, is_wr;
    logic [7:0] since_q;

    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
    assign is_wr  = !cs_n &&  ras_n && !cas_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_q <= 8'(T_RCD);
        else if (is_act)            since_q <= 8'd1;
        else if (since_q < 8'(T_RCD)) since_q <= since_q + 8'd1;
    end

    p_cmd_after_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> $past(cke));

    p_rw_autopre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> a10);

    p_act_to_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_q >= 8'(T_RCD)));

    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(is_rd, CAS_LAT + 1));

    p_oe_only_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> is_wr);

    p_refresh_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

endmodule

bind sdr_seq_ctrl sdr_seq_chk #(.CAS_LAT(CAS_LAT), .T_RCD(T_RCD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (sd_cke),
    .cs_n     (sd_cs_n),
    .ras_n    (sd_ras_n),
    .cas_n    (sd_cas_n),
    .we_n     (sd_we_n),
    .a10      (sd_addr[10]),
    .dq_oe    (sd_dq_oe),
    .rsp_valid(rsp_valid),
    .ref_pend (ref_pend),
    .req_ready(req_ready)
);

// File: tb/sim_sdr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sdr_seq_ctrl;
    localparam int CL       = 3;
    localparam int CLK_MHZ  = 4;
    localparam int INIT_CYC = 40;
    localparam int T_RCD    = 3;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 7;
    localparam int T_WR     = 2;
    localparam int REFI     = (CLK_MHZ * 64000) / 4096;
    localparam int BOUND    = REFI + T_RCD + T_WR + T_RP + CL + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = 16'hC0DE;

    sdr_seq_ctrl #(.CAS_LAT(CL), .CLK_MHZ(CLK_MHZ), .INIT_CYC(INIT_CYC),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in));

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [21:0] a);
        return a[15:0] ^ 16'h5A5A ^ {a[21:16], 10'd0};
    endfunction

    // behavioural memory and pin monitor
    logic [15:0] mem [int];
    logic [15:0] shadow [int];
    bit          is_open [4];
    int          act_at [4], free_at [4];
    int          last_ref = 0, n_ref = 0, init_idx = 0, rd_cnt = 0;
    logic        cke_prev = 1'b0;
    logic [15:0] rd_word;
    int          rdc_q [$];
    logic [15:0] exp_q [$];
    logic [21:0] cur_addr;

    always @(negedge clk) begin : model
        logic [3:0]  c;
        logic [21:0] k;
        logic [15:0] w;
        cyc++;
        if (rsp_valid) begin
            chk(exp_q.size() > 0 && rdc_q.size() > 0, "R6 unexpected response", 1, 0);
            if (exp_q.size() > 0 && rdc_q.size() > 0) begin
                w = exp_q.pop_front();
                chk(rsp_rdata == w, "R6 read data", rsp_rdata, w);
                k = 22'(rdc_q.pop_front());
                chk(cyc - int'(k) == CL + 1, "R6 latency", cyc - int'(k), CL + 1);
            end
        end
        if (rd_cnt > 0) begin
            rd_cnt--;
            sd_dq_in = (rd_cnt == 0) ? rd_word : 16'hC0DE;
        end else begin
            sd_dq_in = 16'hC0DE;
        end
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(!(sd_dq_oe && c != 4'b0100), "R7 oe outside write", {28'd0, c}, 32'h4);
        if (!sd_cs_n) begin
            chk(cke_prev && sd_cke, "R1 cke before command", cke_prev, 1);
            chk(cyc > INIT_CYC, "R1 init wait", cyc, INIT_CYC);
            if (init_idx < 4 && c != 4'b0111) begin
                case (init_idx)
                    0: chk(c == 4'b0010 && sd_addr[10], "R2 step precharge-all", {c, sd_addr}, 32'h2400);
                    1, 2: chk(c == 4'b0001, "R2 step refresh", c, 1);
                    default: chk(c == 4'b0000 && sd_ba == 0 && sd_addr[3:0] == 0
                                 && sd_addr[6:4] == 3'(CL), "R2 mode word", {c, sd_addr}, {4'd0, 12'(CL << 4)});
                endcase
                init_idx++;
            end
            k = {sd_ba, sd_addr[11:0], 8'd0};
            case (c)
                4'b0111, 4'b0000: ;
                4'b0010: for (int b = 0; b < 4; b++) begin is_open[b] = 0; free_at[b] = cyc + T_RP; end
                4'b0001: begin
                    for (int b = 0; b < 4; b++)
                        chk(!is_open[b] && cyc >= free_at[b], "R5 refresh while bank busy", cyc, free_at[b]);
                    if (n_ref > 0) chk(cyc - last_ref >= T_RFC, "R5 refresh to refresh", cyc - last_ref, T_RFC);
                    if (init_idx >= 4) chk(cyc - last_ref <= BOUND, "R8 refresh gap", cyc - last_ref, BOUND);
                    last_ref = cyc; n_ref++;
                end
                4'b0011: begin
                    chk(!is_open[sd_ba] && cyc >= free_at[sd_ba], "R5 activate before precharge done", cyc, free_at[sd_ba]);
                    chk(cyc - last_ref >= T_RFC, "R5 activate after refresh", cyc - last_ref, T_RFC);
                    chk({sd_ba, sd_addr} == cur_addr[21:8], "R3 activate bank/row", {sd_ba, sd_addr}, cur_addr[21:8]);
                    is_open[sd_ba] = 1; act_at[sd_ba] = cyc;
                end
                4'b0100, 4'b0101: begin
                    chk(is_open[sd_ba] && cyc - act_at[sd_ba] >= T_RCD, "R5 activate to access", cyc - act_at[sd_ba], T_RCD);
                    chk(sd_ba == cur_addr[21:20] && sd_addr[7:0] == cur_addr[7:0] && sd_addr[10],
                        "R3 access bank/column/autoprecharge", {sd_ba, sd_addr}, {cur_addr[21:20], 4'b0100, cur_addr[7:0]});
                    k = cur_addr;
                    w = mem.exists(int'(k)) ? mem[int'(k)] : init_word(k);
                    is_open[sd_ba] = 0;
                    if (c == 4'b0100) begin
                        chk(sd_dq_oe, "R7 oe with write", sd_dq_oe, 1);
                        if (!sd_dqm[0]) w[7:0]  = sd_dq_out[7:0];
                        if (!sd_dqm[1]) w[15:8] = sd_dq_out[15:8];
                        mem[int'(k)] = w;
                        free_at[sd_ba] = cyc + T_WR + T_RP;
                    end else begin
                        rd_word = w; rd_cnt = CL; rdc_q.push_back(cyc);
                        free_at[sd_ba] = cyc + 1 + T_RP;
                    end
                end
                default: chk(0, "R4 illegal command", {28'd0, c}, 32'h7);
            endcase
        end
        cke_prev = sd_cke;
    end

    task automatic do_op(input bit we, input logic [21:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_addr = a;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
        w = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
        if (we) begin
            if (!m[0]) w[7:0]  = d[7:0];
            if (!m[1]) w[15:8] = d[15:8];
            shadow[int'(a)] = w;
        end else begin
            exp_q.push_back(w);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
    endtask

    function automatic logic [21:0] pick_addr();
        logic [11:0] r;
        logic [7:0]  cl;
        case ($urandom % 3)
            0: r = 12'h000; 1: r = 12'hFFF; default: r = 12'($urandom % 4);
        endcase
        case ($urandom % 3)
            0: cl = 8'h00; 1: cl = 8'hFF; default: cl = 8'($urandom % 4);
        endcase
        return {2'($urandom % 4), r, cl};
    endfunction

    initial begin : stim
        int rb, c0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sd_cke == 0, "R1 cke low after reset", sd_cke, 0);
        chk(sd_cs_n == 1, "R1 deselected after reset", sd_cs_n, 1);
        chk(req_ready == 0, "R2 not ready during start-up", req_ready, 0);
        while (!req_ready) @(negedge clk);
        chk(init_idx == 4, "R2 ready only after mode set", init_idx, 4);
        // directed byte-lane and boundary cases
        do_op(1, 22'h3FFFFF, 16'h1234, 2'b00);
        do_op(0, 22'h3FFFFF, 0, 0);
        do_op(1, 22'h3FFFFF, 16'hABCD, 2'b01);   // R7 low lane blocked
        do_op(0, 22'h3FFFFF, 0, 0);
        do_op(1, 22'h3FFFFF, 16'h5566, 2'b10);   // R7 high lane blocked
        do_op(0, 22'h3FFFFF, 0, 0);
        do_op(1, 22'h3FFFFF, 16'hFFFF, 2'b11);   // R7 both lanes blocked
        do_op(0, 22'h3FFFFF, 0, 0);
        do_op(0, 22'h000000, 0, 0);
        do_op(1, 22'h000000, 16'h0F0F, 2'b00);
        do_op(0, 22'h000000, 0, 0);
        do_op(0, 22'h2ABC55, 0, 0);
        // streamed random traffic against periodic refresh
        rb = n_ref; c0 = cyc;
        for (int i = 0; i < 300; i++)
            do_op(1'($urandom % 2), pick_addr(), 16'($urandom), 2'($urandom % 4));
        chk(n_ref - rb >= (cyc - c0) / BOUND, "R9 refresh not starved by stream", n_ref - rb, (cyc - c0) / BOUND);
        repeat (4 * REFI) @(negedge clk);
        chk(cyc - last_ref <= BOUND, "R8 refresh continues when idle", cyc - last_ref, BOUND);
        chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule